// File: doc/BRIEF.md
# Bus-Cycle Break Comparator

This block watches the bus cycles of two masters, a processor and a DMA engine, and tests each cycle against a programmed break condition. The condition has four parts: an address with a per-bit ignore mask, a choice of which masters count, a read/write filter and an access-size filter. A cycle that meets every part is a hit.

A hit does three things. It sets a sticky status flag. It raises a level interrupt request when the interrupt is enabled. It starts a trigger pulse on a dedicated output, and the length of that pulse is programmable in clock periods. Software sets up the condition through a small word-addressed register port and reads the flag back through the same port. Software clears the flag by writing zero to it.

Both observed buses are snooped, not handshaken. Each carries a plain valid strobe, and the block never stalls a master. A cycle counts on any clock edge where its valid is high. The processor bus and the DMA bus can each present a cycle on the same edge.

Top module: `bus_break_unit`

## Requirements
- R1: Address match: a cycle's address matches when every bit whose mask bit is 0 equals the compare register. A mask bit of 1 means that bit is ignored. Offset 0 holds the compare value and offset 1 holds the mask.
- R2: Master select: control bit 0 lets processor cycles match and control bit 1 lets DMA cycles match. With both bits 0, nothing matches.
- R3: Direction filter: control bits [3:2] select 01 = reads only, 10 = writes only, 00 or 11 = either direction.
- R4: Size filter: control bits [5:4] select 00 = any size, 01 = byte, 10 = word, 11 = longword. The bus size encoding is 00 byte, 01 word, 10 longword.
- R5: The status flag (offset 3, bit 0) is set on the clock edge of a hit and stays set. A register write to offset 3 with bit 0 = 0 clears it. A write with bit 0 = 1 has no effect. A hit on the same edge as a clear leaves the flag set.
- R6: irq_req is high exactly when the flag is set and control bit 8 (interrupt enable) is 1. With the enable at 0, a hit still sets the flag.
- R7: A hit drives trig_out high from the following clock edge. The pulse lasts 1, 4, 8 or 16 clock periods for control bits [7:6] = 00, 01, 10, 11.
- R8: A hit while a pulse is active restarts the full programmed width. It does not queue a second pulse.
- R9: After reset, all registers read 0 and irq_req and trig_out are low.
- R10: Offsets 0 to 2 read back the value last written, zero-extended. The read is combinational on cfg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cpu_valid | input | 1 | Processor bus cycle present |
| cpu_addr | input | 24 | Processor cycle address |
| cpu_write | input | 1 | Processor cycle is a write |
| cpu_size | input | 2 | Processor cycle size |
| dma_valid | input | 1 | DMA bus cycle present |
| dma_addr | input | 24 | DMA cycle address |
| dma_write | input | 1 | DMA cycle is a write |
| dma_size | input | 2 | DMA cycle size |
| irq_req | output | 1 | Interrupt request level |
| trig_out | output | 1 | Break trigger pulse |

## Verification
Two cases are hard to reach from the ports. The first is a software clear that lands on the same edge as a new hit. The second is a hit that arrives while a pulse is still counting down. The bench reaches both by driving the register write and the bus valid together at one falling edge. For the restart case, it issues the second matching cycle a few periods into a long pulse and then counts the remaining high periods. A table of condition/cycle pairs covers the filters, and directed sequences cover every width code and the interrupt masking.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int NUM_MASTERS = 2;
  localparam int MST_CPU     = 0;
  localparam int MST_DMA     = 1;

  localparam logic [1:0] OFS_CMP    = 2'd0;
  localparam logic [1:0] OFS_MASK   = 2'd1;
  localparam logic [1:0] OFS_CTRL   = 2'd2;
  localparam logic [1:0] OFS_STATUS = 2'd3;

  localparam logic [1:0] DIR_RD = 2'b01;
  localparam logic [1:0] DIR_WR = 2'b10;

  localparam int CTRL_W  = 9;
  localparam int PCNT_W  = 5;

  // Control register image, LSB first: master enables, direction, size, width, irq enable
  typedef struct packed {
    logic       irq_en;
    logic [1:0] width;
    logic [1:0] size_sel;
    logic [1:0] dir_sel;
    logic [1:0] mst_en;
  } ctrl_t;

  function automatic logic [PCNT_W-1:0] pulse_len(input logic [1:0] code);
    case (code)
      2'b00:   pulse_len = PCNT_W'(1);
      2'b01:   pulse_len = PCNT_W'(4);
      2'b10:   pulse_len = PCNT_W'(8);
      default: pulse_len = PCNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/bbc_match.sv
module bbc_match
  import bbc_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          en,
  input  logic [AW-1:0] cmp,
  input  logic [AW-1:0] mask,
  input  logic [1:0]    dir_sel,
  input  logic [1:0]    size_sel,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [1:0]    size,
  output logic          hit
);
  logic addr_ok, dir_ok, size_ok;

  always_comb begin
    addr_ok = (((addr ^ cmp) & ~mask) == '0);
    case (dir_sel)
      DIR_RD:  dir_ok = !write;
      DIR_WR:  dir_ok = write;
      default: dir_ok = 1'b1;
    endcase
    if (size_sel == 2'b00) size_ok = 1'b1;
    else                   size_ok = (size == (size_sel - 2'd1));
    hit = en && valid && addr_ok && dir_ok && size_ok;
  end
endmodule

// File: rtl/bbc_regs.sv
module bbc_regs
  import bbc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          hit,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] cmp,
  output logic [AW-1:0] mask,
  output ctrl_t         ctrl,
  output logic          flag
);
  logic clr_req;
  logic unused_wbits;

  assign clr_req      = we && (addr == OFS_STATUS) && !wdata[0];
  assign unused_wbits = ^wdata[DW-1:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      mask <= '0;
      ctrl <= '0;
    end else if (we) begin
      case (addr)
        OFS_CMP:  cmp  <= wdata[AW-1:0];
        OFS_MASK: mask <= wdata[AW-1:0];
        OFS_CTRL: ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    case (addr)
      OFS_CMP:  rdata = DW'(cmp);
      OFS_MASK: rdata = DW'(mask);
      OFS_CTRL: rdata = DW'(ctrl);
      default:  rdata = DW'(flag);
    endcase
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/bbc_pulse.sv
module bbc_pulse
  import bbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] width,
  output logic       trig
);
  logic [PCNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (fire)        remain <= pulse_len(width);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign trig = (remain != '0);

  // R7
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trig);

  // R8
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && remain != '0) |=> (remain == $past(remain) - 1'b1));

  // R7
  trig_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && remain == PCNT_W'(1)) |=> !trig);
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          cpu_valid,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_write,
  input  logic [1:0]    cpu_size,
  input  logic          dma_valid,
  input  logic [AW-1:0] dma_addr,
  input  logic          dma_write,
  input  logic [1:0]    dma_size,
  output logic          irq_req,
  output logic          trig_out
);
  logic [AW-1:0] cmp, mask;
  ctrl_t         ctrl;
  logic          flag;
  logic          hit_any;

  logic [NUM_MASTERS-1:0]         m_valid, m_write, m_hit;
  logic [NUM_MASTERS-1:0][AW-1:0] m_addr;
  logic [NUM_MASTERS-1:0][1:0]    m_size;

  assign m_valid[MST_CPU] = cpu_valid;
  assign m_write[MST_CPU] = cpu_write;
  assign m_addr[MST_CPU]  = cpu_addr;
  assign m_size[MST_CPU]  = cpu_size;
  assign m_valid[MST_DMA] = dma_valid;
  assign m_write[MST_DMA] = dma_write;
  assign m_addr[MST_DMA]  = dma_addr;
  assign m_size[MST_DMA]  = dma_size;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_cmp
    bbc_match #(.AW(AW)) u_match (
      .en       (ctrl.mst_en[m]),
      .cmp      (cmp),
      .mask     (mask),
      .dir_sel  (ctrl.dir_sel),
      .size_sel (ctrl.size_sel),
      .valid    (m_valid[m]),
      .addr     (m_addr[m]),
      .write    (m_write[m]),
      .size     (m_size[m]),
      .hit      (m_hit[m])
    );
  end

  assign hit_any = |m_hit;

  bbc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .hit   (hit_any),
    .rdata (cfg_rdata),
    .cmp   (cmp),
    .mask  (mask),
    .ctrl  (ctrl),
    .flag  (flag)
  );

  bbc_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (hit_any),
    .width (ctrl.width),
    .trig  (trig_out)
  );

  assign irq_req = flag && ctrl.irq_en;

  // R2
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((cpu_valid && ctrl.mst_en[MST_CPU]) || (dma_valid && ctrl.mst_en[MST_DMA])));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(hit_any) || $past(cfg_we)));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq_req && !trig_out));
endmodule

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0, dma_valid = 1'b0, dma_write = 1'b0;
  logic [23:0] cpu_addr = '0, dma_addr = '0;
  logic [1:0]  cpu_size = '0, dma_size = '0;
  logic        irq_req, trig_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_break_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_size(cpu_size),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_write(dma_write), .dma_size(dma_size),
    .irq_req(irq_req), .trig_out(trig_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [23:0] cmp;
    logic [23:0] mask;
    logic [8:0]  ctrl;
    logic        dma;
    logic [23:0] addr;
    logic        wr;
    logic [1:0]  sz;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 24'h123456, 24'h000000, 9'h001, 1'b0, 24'h123456, 1'b0, 2'b00, 1'b1}, // R1 exact
    '{4'd1, 24'h123456, 24'h000000, 9'h001, 1'b0, 24'h123457, 1'b0, 2'b00, 1'b0}, // R1 one bit off
    '{4'd1, 24'h123456, 24'h00000F, 9'h001, 1'b0, 24'h12345A, 1'b0, 2'b00, 1'b1}, // R1 masked nibble
    '{4'd1, 24'h123456, 24'h00000F, 9'h001, 1'b0, 24'h12355A, 1'b0, 2'b00, 1'b0}, // R1 unmasked differs
    '{4'd2, 24'h123456, 24'h000000, 9'h001, 1'b1, 24'h123456, 1'b0, 2'b00, 1'b0}, // R2 dma not selected
    '{4'd2, 24'h123456, 24'h000000, 9'h002, 1'b1, 24'h123456, 1'b0, 2'b00, 1'b1}, // R2 dma selected
    '{4'd2, 24'h123456, 24'h000000, 9'h003, 1'b0, 24'h123456, 1'b0, 2'b00, 1'b1}, // R2 both selected
    '{4'd2, 24'h123456, 24'h000000, 9'h000, 1'b0, 24'h123456, 1'b0, 2'b00, 1'b0}, // R2 none selected
    '{4'd3, 24'h123456, 24'h000000, 9'h005, 1'b0, 24'h123456, 1'b1, 2'b00, 1'b0}, // R3 reads only, write
    '{4'd3, 24'h123456, 24'h000000, 9'h005, 1'b0, 24'h123456, 1'b0, 2'b00, 1'b1}, // R3 reads only, read
    '{4'd3, 24'h123456, 24'h000000, 9'h009, 1'b0, 24'h123456, 1'b1, 2'b00, 1'b1}, // R3 writes only, write
    '{4'd4, 24'h123456, 24'h000000, 9'h021, 1'b0, 24'h123456, 1'b0, 2'b01, 1'b1}, // R4 word/word
    '{4'd4, 24'h123456, 24'h000000, 9'h021, 1'b0, 24'h123456, 1'b0, 2'b10, 1'b0}, // R4 word/long
    '{4'd4, 24'h123456, 24'h000000, 9'h031, 1'b0, 24'h123456, 1'b0, 2'b10, 1'b1}  // R4 long/long
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic bus_cyc(input logic dma, input logic [23:0] a, input logic wr, input logic [1:0] sz);
    @(negedge clk);
    if (dma) begin dma_valid = 1'b1; dma_addr = a; dma_write = wr; dma_size = sz; end
    else     begin cpu_valid = 1'b1; cpu_addr = a; cpu_write = wr; cpu_size = sz; end
    @(negedge clk);
    cpu_valid = 1'b0; dma_valid = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (trig_out && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      cfg_read(a[1:0], rd);
      check("R9 reg", rd, 32'h0);
    end
    check("R9 irq", {31'b0, irq_req}, 32'h0);
    check("R9 trig", {31'b0, trig_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 readback
    cfg_write(2'd0, 32'hFFAB_CDEF);
    cfg_write(2'd1, 32'h0000_0F0F);
    cfg_write(2'd2, 32'hFFFF_FFFF);
    cfg_read(2'd0, rd); check("R10 cmp", rd, 32'h00AB_CDEF);
    cfg_read(2'd1, rd); check("R10 mask", rd, 32'h0000_0F0F);
    cfg_read(2'd2, rd); check("R10 ctrl", rd, 32'h0000_01FF);
    cfg_write(2'd2, 32'h0);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, {8'h0, VEC[i].cmp});
      cfg_write(2'd1, {8'h0, VEC[i].mask});
      cfg_write(2'd2, {23'h0, VEC[i].ctrl});
      cfg_write(2'd3, 32'h0);
      bus_cyc(VEC[i].dma, VEC[i].addr, VEC[i].wr, VEC[i].sz);
      cfg_read(2'd3, rd);
      check($sformatf("R%0d vec%0d flag", VEC[i].req, i), rd, {31'b0, VEC[i].exp});
      check($sformatf("R%0d vec%0d trig", VEC[i].req, i), {31'b0, trig_out}, {31'b0, VEC[i].exp});
      repeat (2) @(negedge clk);
    end

    cfg_write(2'd0, 32'h0000_1000);
    cfg_write(2'd1, 32'h0);

    // R7 all width codes
    for (int w = 0; w < 4; w++) begin
      cfg_write(2'd2, 32'h001 | (w << 6));
      bus_cyc(1'b0, 24'h001000, 1'b0, 2'b00);
      count_high(n);
      check($sformatf("R7 width code %0d", w), n, (w == 0) ? 1 : (w == 1) ? 4 : (w == 2) ? 8 : 16);
    end

    // R8 restart mid-pulse
    cfg_write(2'd2, 32'h081);
    bus_cyc(1'b0, 24'h001000, 1'b0, 2'b00);
    repeat (2) @(negedge clk);
    bus_cyc(1'b0, 24'h001000, 1'b0, 2'b00);
    count_high(n);
    check("R8 restart length", n, 8);

    // R6 masked interrupt still flags
    cfg_write(2'd3, 32'h0);
    cfg_write(2'd2, 32'h001);
    bus_cyc(1'b0, 24'h001000, 1'b0, 2'b00);
    cfg_read(2'd3, rd);
    check("R6 flag while masked", rd, 32'h1);
    check("R6 irq masked", {31'b0, irq_req}, 32'h0);
    cfg_write(2'd2, 32'h101);
    check("R6 irq enabled", {31'b0, irq_req}, 32'h1);
    cfg_write(2'd3, 32'h0);
    check("R6 irq after clear", {31'b0, irq_req}, 32'h0);

    // R5 write of 1 ignored, sticky, set beats clear
    cfg_write(2'd3, 32'h1);
    cfg_read(2'd3, rd);
    check("R5 write one no effect", rd, 32'h0);
    bus_cyc(1'b0, 24'h001000, 1'b0, 2'b00);
    repeat (20) @(negedge clk);
    cfg_read(2'd3, rd);
    check("R5 sticky", rd, 32'h1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h0;
    cpu_valid = 1'b1; cpu_addr = 24'h001000; cpu_write = 1'b0; cpu_size = 2'b00;
    @(negedge clk);
    cfg_we = 1'b0; cpu_valid = 1'b0;
    cfg_read(2'd3, rd);
    check("R5 set wins over clear", rd, 32'h1);
    cfg_write(2'd3, 32'h0);
    cfg_read(2'd3, rd);
    check("R5 clear", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule